// File: doc/BRIEF.md
# Ethernet Receive Frame Filter FIFO

This block is a byte-wide receive buffer that sits between a MAC receive byte stream and a memory-side consumer. It stores each incoming frame and decides whether the frame is forwarded or discarded. The decision depends on four configuration inputs and on whether any part of the frame has already been handed to the consumer. The consumer side is a valid/ready byte stream. It carries start-of-frame and end-of-frame markers and an error tag on the last byte.

In cut-through mode a frame is exposed to the consumer once enough of it has been buffered or once it has ended, whichever happens first. The two-bit threshold code sets the release level. In store-and-forward mode a frame is exposed only after its last byte has arrived. A frame that is rejected before release is removed by rewinding the write pointer to the frame's first entry, so none of its bytes ever appear. A frame that has been partly released is always delivered in full.

A write state machine handles the input side and has four states. W_IDLE waits for a start marker. W_FILL buffers a frame that the consumer cannot see yet. W_PASS buffers a frame that has been released. W_SKIP discards input until the next end marker. Its transitions are:
- W_IDLE to W_FILL or W_PASS on the first byte of a frame.
- W_FILL to W_PASS when the threshold is reached.
- W_FILL or W_PASS to W_IDLE on the last byte, which either commits or rewinds the frame.
- W_FILL or W_PASS to W_SKIP on overflow.
- W_IDLE to W_SKIP when a frame starts and the FIFO has no room.
- W_SKIP to W_IDLE on an end marker.

A read state machine handles the output side and has two states. R_HEAD means the next byte opens a frame. R_BODY means the next byte is inside a frame. It moves from R_HEAD to R_BODY on a handshake of a byte that is not the last of its frame, and back to R_HEAD on a handshake of a last byte.

Top module: `rxf_filter`

## Requirements
- R1: In cut-through mode (`cfg_store_fwd`=0), the release level set by `cfg_thresh` is 64 bytes for code 0, 32 for code 1, 96 for code 2 and 128 for code 3. The first byte of a frame becomes visible on the output in the cycle after the byte that brings the frame's buffered count to that level is accepted, or after the frame's last byte if that comes first.
- R2: In store-and-forward mode (`cfg_store_fwd`=1), no byte of a frame is visible before its last byte has been accepted, whatever the value of `cfg_thresh`.
- R3: In cut-through mode with `cfg_fwd_err`=0, an errored frame (`in_err`=1 with its last byte) that is not longer than the release level is dropped. A longer errored frame is forwarded in full, with `out_err`=1 on its last byte.
- R4: In store-and-forward mode with `cfg_fwd_err`=0, every frame marked with `in_err` or `in_runt` is dropped.
- R5: With `cfg_fwd_err`=1, frames marked with `in_err` are forwarded, short ones included. `out_err` is 1 only on such a frame's last byte. Frames marked with `in_runt` are still dropped unless they were already released.
- R6: With `cfg_fwd_small`=0, an error-free frame shorter than 64 bytes is dropped unless it was already released. A frame of exactly 64 bytes is kept.
- R7: With `cfg_fwd_small`=1, error-free frames shorter than 64 bytes are forwarded, down to a single byte marked as both first and last.
- R8: `out_sof` is 1 on exactly the first byte of each forwarded frame and `out_eof` on exactly its last. While `out_valid`=1 and `out_ready`=0, the output byte and its markers stay unchanged.
- R9: A byte that is not a frame's last and arrives while DEPTH-1 entries are occupied counts as an overflow. If the frame was already released or `cfg_fwd_err`=1, that byte is stored as the frame's last byte with `out_err`=1. Otherwise the whole frame is dropped. In both cases the rest of the input frame is ignored up to its end marker. A frame that starts while DEPTH-1 or more entries are occupied is dropped.
- R10: A dropped frame produces no output byte at all. Frames before and after it come out intact and in order.
- R11: After reset, `out_valid` is 0 and the first byte delivered carries `out_sof`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input byte is present this cycle |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_err | input | 1 | Frame error status, sampled with the last byte |
| in_runt | input | 1 | Runt status, sampled with the last byte |
| cfg_store_fwd | input | 1 | 1: store-and-forward, 0: cut-through |
| cfg_thresh | input | 2 | Cut-through release level code |
| cfg_fwd_err | input | 1 | Forward frames carrying errors other than runt |
| cfg_fwd_small | input | 1 | Forward error-free frames under 64 bytes |
| out_valid | output | 1 | An output byte is available |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| out_err | output | 1 | Forwarded frame carries an error (last byte only) |

## Verification
Frames with lengths on both sides of each release level and of the 64-byte minimum are sent with the consumer stalled. The cycle at which the first byte appears separates cut-through release from store-and-forward release, and it also confirms each threshold code. Errored, runt and short frames are sent under each forwarding setting, with lengths placed just below and just above the release level. This shows whether the drop decision follows the error class, the frame length and whether the frame was already released. Frames longer than the buffer, sent with the consumer stalled, separate the rewind path from the truncate-and-tag path. A mixed sequence under a pseudo-random ready pattern checks that rewinds never leak bytes into the frames next to a dropped one.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        W_IDLE,
        W_FILL,
        W_PASS,
        W_SKIP
    } wr_state_t;

    typedef enum logic {
        R_HEAD,
        R_BODY
    } rd_state_t;

    typedef struct packed {
        logic       err;
        logic       last;
        logic [7:0] data;
    } rxf_entry_t;

    // Cut-through release level in bytes for a threshold code
    function automatic logic [7:0] thr_bytes(input logic [1:0] code);
        logic [7:0] lvl;
        unique case (code)
            2'd0:    lvl = 8'd64;
            2'd1:    lvl = 8'd32;
            2'd2:    lvl = 8'd96;
            default: lvl = 8'd128;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxf_mem.sv
module rxf_mem
    import rxf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  rxf_entry_t               wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output rxf_entry_t               rdata
);

    rxf_entry_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [7:0]               in_data,
    input  logic                     in_sof,
    input  logic                     in_eof,
    input  logic                     in_err,
    input  logic                     in_runt,
    input  logic                     cfg_store_fwd,
    input  logic [1:0]               cfg_thresh,
    input  logic                     cfg_fwd_err,
    input  logic                     cfg_fwd_small,
    input  logic [$clog2(DEPTH):0]   rd_ptr,
    output logic                     mem_we,
    output logic [$clog2(DEPTH)-1:0] mem_waddr,
    output rxf_entry_t               mem_wdata,
    output logic [$clog2(DEPTH):0]   wr_ptr,
    output logic [$clog2(DEPTH):0]   commit_ptr
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    wr_state_t        state_q, state_d;
    logic [LEN_W-1:0] fcnt_q, fcnt_d;
    logic [PW-1:0]    fstart_q, fstart_d;
    logic [PW-1:0]    wr_q, wr_d;
    logic [PW-1:0]    cm_q, cm_d;

    logic [PW-1:0]    level;
    logic             last_slot;
    logic             no_room;
    logic             in_frame;
    logic             take;
    logic             released;
    logic             errored;
    logic             short_frm;
    logic             keep;
    logic             thr_hit;
    logic [PW-1:0]    base;
    logic [LEN_W-1:0] cnt_nx;
    logic [PW-1:0]    wr_inc;

    assign level     = wr_q - rd_ptr;
    assign last_slot = (level == PW'(DEPTH - 1));
    assign no_room   = (level >= PW'(DEPTH - 1));
    assign in_frame  = (state_q == W_FILL) || (state_q == W_PASS);
    assign take      = in_valid && (((state_q == W_IDLE) && in_sof && !no_room) || in_frame);
    assign released  = (state_q == W_PASS);
    assign base      = (state_q == W_IDLE) ? wr_q : fstart_q;
    assign cnt_nx    = (state_q == W_IDLE) ? LEN_W'(1)
                     : ((fcnt_q == '1) ? fcnt_q : fcnt_q + 1'b1);
    assign errored   = in_err || in_runt;
    assign short_frm = (cnt_nx < LEN_W'(MIN_LEN));
    assign keep      = released
                     || (errored ? (cfg_fwd_err && !in_runt)
                                 : (!short_frm || cfg_fwd_small));
    assign thr_hit   = !cfg_store_fwd && (cnt_nx >= LEN_W'(thr_bytes(cfg_thresh)));
    assign wr_inc    = wr_q + 1'b1;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Pointer and frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt_q   <= '0;
            fstart_q <= '0;
            wr_q     <= '0;
            cm_q     <= '0;
        end else begin
            fcnt_q   <= fcnt_d;
            fstart_q <= fstart_d;
            wr_q     <= wr_d;
            cm_q     <= cm_d;
        end
    end

    // Next state and write actions
    always_comb begin
        state_d        = state_q;
        fcnt_d         = fcnt_q;
        fstart_d       = fstart_q;
        wr_d           = wr_q;
        cm_d           = cm_q;
        mem_we         = 1'b0;
        mem_wdata.err  = 1'b0;
        mem_wdata.last = 1'b0;
        mem_wdata.data = in_data;

        unique case (state_q)
            W_IDLE: begin
                if (in_valid && in_sof && no_room && !in_eof) begin
                    state_d = W_SKIP;
                end
            end
            W_FILL, W_PASS: begin
                state_d = state_q;
            end
            W_SKIP: begin
                if (in_valid && in_eof) begin
                    state_d = W_IDLE;
                end
            end
            default: state_d = W_IDLE;
        endcase

        if (take) begin
            fstart_d = base;
            fcnt_d   = cnt_nx;
            if (!in_eof && last_slot) begin
                // overflow: truncate a frame that must go out, else rewind
                if (released || cfg_fwd_err) begin
                    mem_we         = 1'b1;
                    mem_wdata.last = 1'b1;
                    mem_wdata.err  = 1'b1;
                    wr_d           = wr_inc;
                    cm_d           = wr_inc;
                end else begin
                    wr_d = base;
                end
                state_d = W_SKIP;
            end else if (in_eof) begin
                if (keep) begin
                    mem_we         = 1'b1;
                    mem_wdata.last = 1'b1;
                    mem_wdata.err  = errored;
                    wr_d           = wr_inc;
                    cm_d           = wr_inc;
                end else begin
                    wr_d = base;
                end
                state_d = W_IDLE;
            end else begin
                mem_we = 1'b1;
                wr_d   = wr_inc;
                if (released || thr_hit) begin
                    cm_d    = wr_inc;
                    state_d = W_PASS;
                end else begin
                    state_d = W_FILL;
                end
            end
        end
    end

    assign mem_waddr  = wr_q[AW-1:0];
    assign wr_ptr     = wr_q;
    assign commit_ptr = cm_q;

endmodule

// File: rtl/rxf_rd_ctrl.sv
module rxf_rd_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(DEPTH):0] commit_ptr,
    input  rxf_entry_t             rdata,
    input  logic                   out_ready,
    output logic [$clog2(DEPTH):0] rd_ptr,
    output logic                   out_valid,
    output logic [7:0]             out_data,
    output logic                   out_sof,
    output logic                   out_eof,
    output logic                   out_err
);

    localparam int PW = $clog2(DEPTH) + 1;

    rd_state_t     state_q, state_d;
    logic [PW-1:0] rd_q;
    logic          fire;

    assign fire = out_valid && out_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= R_HEAD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (fire) begin
            rd_q <= rd_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_HEAD: if (fire && !rdata.last) state_d = R_BODY;
            R_BODY: if (fire && rdata.last)  state_d = R_HEAD;
            default: state_d = R_HEAD;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid = (rd_q != commit_ptr);
        out_data  = rdata.data;
        out_sof   = out_valid && (state_q == R_HEAD);
        out_eof   = out_valid && rdata.last;
        out_err   = out_valid && rdata.err;
    end

    assign rd_ptr = rd_q;

endmodule

// File: rtl/rxf_filter.sv
module rxf_filter
    import rxf_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       in_err,
    input  logic       in_runt,
    input  logic       cfg_store_fwd,
    input  logic [1:0] cfg_thresh,
    input  logic       cfg_fwd_err,
    input  logic       cfg_fwd_small,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_err
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    rxf_entry_t    mem_wdata;
    rxf_entry_t    mem_rdata;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] commit_ptr;

    rxf_wr_ctrl #(
        .DEPTH   (DEPTH),
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_sof        (in_sof),
        .in_eof        (in_eof),
        .in_err        (in_err),
        .in_runt       (in_runt),
        .cfg_store_fwd (cfg_store_fwd),
        .cfg_thresh    (cfg_thresh),
        .cfg_fwd_err   (cfg_fwd_err),
        .cfg_fwd_small (cfg_fwd_small),
        .rd_ptr        (rd_ptr),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .mem_wdata     (mem_wdata),
        .wr_ptr        (wr_ptr),
        .commit_ptr    (commit_ptr)
    );

    rxf_mem #(
        .DEPTH (DEPTH)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (mem_rdata)
    );

    rxf_rd_ctrl #(
        .DEPTH (DEPTH)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_ptr (commit_ptr),
        .rdata      (mem_rdata),
        .out_ready  (out_ready),
        .rd_ptr     (rd_ptr),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_sof    (out_sof),
        .out_eof    (out_eof),
        .out_err    (out_err)
    );

endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk #(
    parameter int DEPTH = 256
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_eof,
    input logic                   cfg_store_fwd,
    input logic                   cfg_fwd_err,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [7:0]             out_data,
    input logic                   out_sof,
    input logic                   out_eof,
    input logic                   out_err,
    input logic [$clog2(DEPTH):0] wr_ptr,
    input logic [$clog2(DEPTH):0] rd_ptr,
    input logic [$clog2(DEPTH):0] commit_ptr
);

    localparam int PW = $clog2(DEPTH) + 1;

    logic [PW-1:0] used_all;
    logic [PW-1:0] used_vis;
    assign used_all = wr_ptr - rd_ptr;
    assign used_vis = commit_ptr - rd_ptr;

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)
                                       && $stable(out_eof) && $stable(out_err)));

    assert_sof_follows_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eof) |=> (!out_valid || out_sof));

    assert_err_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> out_eof);

    assert_sf_commit_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_store_fwd && !cfg_fwd_err && !(in_valid && in_eof)) |=> $stable(commit_ptr));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (used_all <= PW'(DEPTH)) && (used_vis <= used_all));

endmodule

bind rxf_filter rxf_filter_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_eof        (in_eof),
    .cfg_store_fwd (cfg_store_fwd),
    .cfg_fwd_err   (cfg_fwd_err),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_sof       (out_sof),
    .out_eof       (out_eof),
    .out_err       (out_err),
    .wr_ptr        (wr_ptr),
    .rd_ptr        (rd_ptr),
    .commit_ptr    (commit_ptr)
);

// File: tb/tb_rxf_filter.sv
`timescale 1ns/1ps
module tb_rxf_filter;

    localparam int DEPTH = 256;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_sof, in_eof, in_err, in_runt;
    logic [7:0] in_data;
    logic       cfg_store_fwd, cfg_fwd_err, cfg_fwd_small;
    logic [1:0] cfg_thresh;
    logic       out_valid, out_ready, out_sof, out_eof, out_err;
    logic [7:0] out_data;

    logic       hold_rdy;
    logic       force_drop;
    logic [7:0] lfsr = 8'h5A;

    int checks = 0;
    int errors = 0;

    logic [10:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign out_ready = !hold_rdy && lfsr[0];

    rxf_filter #(.DEPTH(DEPTH)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_sof        (in_sof),
        .in_eof        (in_eof),
        .in_err        (in_err),
        .in_runt       (in_runt),
        .cfg_store_fwd (cfg_store_fwd),
        .cfg_thresh    (cfg_thresh),
        .cfg_fwd_err   (cfg_fwd_err),
        .cfg_fwd_small (cfg_fwd_small),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_data      (out_data),
        .out_sof       (out_sof),
        .out_eof       (out_eof),
        .out_err       (out_err)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int thr_of(input logic [1:0] code);
        case (code)
            2'd0:    return 64;
            2'd1:    return 32;
            2'd2:    return 96;
            default: return 128;
        endcase
    endfunction

    // Driver: model the expected outcome, queue it, then drive the frame
    task automatic send_frame(input int len, input bit err, input bit runt,
                              input logic [7:0] seed, input string tag, output int first_valid);
        int thr = thr_of(cfg_thresh);
        bit ct  = !cfg_store_fwd;
        bit keep;
        bit etag;
        int n_out;
        if (hold_rdy && len > DEPTH) begin
            keep  = (ct && (DEPTH - 1) >= thr) || cfg_fwd_err;
            n_out = DEPTH;
            etag  = 1'b1;
        end else begin
            keep  = (ct && len > thr)
                 || ((err || runt) ? (cfg_fwd_err && !runt) : (len >= 64 || cfg_fwd_small));
            n_out = len;
            etag  = err || runt;
        end
        if (force_drop) keep = 1'b0;
        if (keep) begin
            for (int i = 0; i < n_out; i++) begin
                exp_q.push_back({(i == 0), (i == n_out - 1), (i == n_out - 1) && etag, 8'(seed + i)});
                tag_q.push_back(tag);
            end
        end
        first_valid = -1;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_err   = err && (i == len - 1);
            in_runt  = runt && (i == len - 1);
            in_data  = 8'(seed + i);
            @(posedge clk); #1;
            if (first_valid < 0 && out_valid) first_valid = i + 1;
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0; in_runt = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic drain(input string tag);
        hold_rdy = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            if (exp_q.size() == 0) break;
            @(posedge clk); #1;
        end
        repeat (8) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, tag, "expected bytes still pending", exp_q.size(), 0);
        chk(!out_valid, tag, "extra output after drain", int'(out_valid), 0);
        hold_rdy = 1'b1;
    endtask

    // Monitor: compare each handshaked byte against the scoreboard queue
    initial begin
        logic [10:0] cur, prev_word, e;
        string       t;
        bit          prev_stall;
        prev_stall = 1'b0;
        prev_word  = '0;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1) begin
                cur = {out_sof, out_eof, out_err, out_data};
                if (prev_stall) chk(out_valid && cur == prev_word, "R8", "stalled byte changed", cur, prev_word);
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R10", "unexpected output byte", cur, 0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(cur == e, t, "output byte {sof,eof,err,data}", cur, e);
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_word  = cur;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int fv;
        rst_n = 1'b0; hold_rdy = 1'b1; force_drop = 1'b0;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0; in_runt = 1'b0; in_data = '0;
        cfg_store_fwd = 1'b1; cfg_thresh = 2'd0; cfg_fwd_err = 1'b0; cfg_fwd_small = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!out_valid, "R11", "out_valid after reset", int'(out_valid), 0);

        // R11: first frame after reset opens with sof
        send_frame(70, 0, 0, 8'h10, "R11", fv);
        drain("R11");

        // R1: each threshold code in cut-through
        cfg_store_fwd = 1'b0;
        for (int c = 0; c < 4; c++) begin
            cfg_thresh = 2'(c);
            send_frame(150, 0, 0, 8'(8'h20 + c), "R1", fv);
            chk(fv == thr_of(2'(c)), "R1", "bytes in before first visible", fv, thr_of(2'(c)));
            drain("R1");
        end

        // R2: store-and-forward ignores threshold
        cfg_store_fwd = 1'b1; cfg_thresh = 2'd1;
        send_frame(150, 0, 0, 8'h30, "R2", fv);
        chk(fv == 150, "R2", "bytes in before first visible", fv, 150);
        drain("R2");

        // R3: cut-through error handling, release level 64
        cfg_store_fwd = 1'b0; cfg_thresh = 2'd0; cfg_fwd_err = 1'b0;
        send_frame(50, 1, 0, 8'h40, "R3", fv);
        send_frame(100, 1, 0, 8'h48, "R3", fv);
        drain("R3");

        // R4: store-and-forward drops errored and runt frames
        cfg_store_fwd = 1'b1;
        send_frame(150, 1, 0, 8'h50, "R4", fv);
        send_frame(20, 0, 1, 8'h54, "R4", fv);
        send_frame(80, 0, 0, 8'h58, "R4", fv);
        drain("R4");

        // R5: error forwarding on
        cfg_fwd_err = 1'b1;
        send_frame(150, 1, 0, 8'h60, "R5", fv);
        send_frame(30, 0, 1, 8'h64, "R5", fv);
        send_frame(30, 1, 0, 8'h68, "R5", fv);
        drain("R5");
        cfg_fwd_err = 1'b0;

        // R6: short frame handling, boundaries at 63/64 and released short frame
        cfg_fwd_small = 1'b0;
        send_frame(40, 0, 0, 8'h70, "R6", fv);
        send_frame(63, 0, 0, 8'h72, "R6", fv);
        send_frame(64, 0, 0, 8'h74, "R6", fv);
        cfg_store_fwd = 1'b0; cfg_thresh = 2'd1;
        send_frame(40, 0, 0, 8'h76, "R6", fv);
        cfg_thresh = 2'd0;
        send_frame(63, 0, 0, 8'h78, "R6", fv);
        send_frame(64, 0, 0, 8'h7A, "R6", fv);
        drain("R6");

        // R7: short frames forwarded
        cfg_store_fwd = 1'b1; cfg_fwd_small = 1'b1;
        send_frame(40, 0, 0, 8'h80, "R7", fv);
        send_frame(1, 0, 0, 8'h84, "R7", fv);
        drain("R7");
        cfg_fwd_small = 1'b0;

        // R9: overflow with rewind, with truncation, and with no room at start
        send_frame(300, 0, 0, 8'h90, "R9", fv);
        send_frame(70, 0, 0, 8'h94, "R9", fv);
        drain("R9");
        cfg_fwd_err = 1'b1;
        send_frame(300, 0, 0, 8'h98, "R9", fv);
        drain("R9");
        cfg_fwd_err = 1'b0;
        cfg_store_fwd = 1'b0; cfg_thresh = 2'd0;
        send_frame(300, 0, 0, 8'hA0, "R9", fv);
        force_drop = 1'b1;
        send_frame(70, 0, 0, 8'hA4, "R9", fv);
        force_drop = 1'b0;
        drain("R9");
        send_frame(70, 0, 0, 8'hA8, "R9", fv);
        drain("R9");

        // R10: mixed keeps and drops under random ready
        cfg_thresh = 2'd1;
        hold_rdy = 1'b0;
        send_frame(20, 0, 0, 8'hB0, "R10", fv);
        send_frame(90, 0, 0, 8'hB4, "R10", fv);
        send_frame(50, 1, 0, 8'hB8, "R10", fv);
        send_frame(25, 1, 0, 8'hBC, "R10", fv);
        send_frame(70, 0, 0, 8'hC0, "R10", fv);
        drain("R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule